// File: doc/BRIEF.md
# Forward Transfer Target Verifier

This block watches the control transfers a processor core retires and checks each one against a list of permitted pairs of source and destination addresses. Software loads the list into an internal table through a configuration write port before the program runs. Each table word packs a 16-bit source address above a 16-bit destination address. When the core reports a direct jump, or a conditional branch that was taken, the block walks the table one entry per clock until it finds the pair. If no entry holds the pair, it raises a forward-edge violation. A branch that falls through never starts a search.

Interrupt entry is checked separately. Four vector registers, each with an enable bit, hold the entry addresses that may be used. An interrupt vector that matches no enabled register raises an interrupt-entry violation one cycle later. While a search is under way the block holds the core with a stall output, and it refuses new transfer reports through a valid/ready handshake.

Top module: `fwd_xfer_guard`

## Requirements
- R1: After reset, `stall` is low, `xfer_ready` is high, and `res_valid`, `viol_valid` and `viol_code` are all zero.
- R2: A table word holds the source address in bits [31:16] and the destination in bits [15:0]. A transfer matches an entry only if the entry is enabled and both halves are equal.
- R3: A transfer accepted with `xfer_jump`=0 and `xfer_taken`=0 starts no search. `stall` stays low and no result is produced.
- R4: A transfer accepted with `xfer_jump`=1 is searched whatever the value of `xfer_taken`. A transfer with `xfer_jump`=0 and `xfer_taken`=1 is also searched.
- R5: The search checks entry k in the k-th cycle after acceptance, counting from 0. A hit on entry k produces a `res_valid` pulse with `res_hit`=1 on the (k+1)-th clock edge after the accepting edge, and `stall` is high until then.
- R6: A miss is reported on the (L+1)-th edge after acceptance, where L is the highest enabled entry index. It is reported on the first edge when no entry is enabled. A miss drives `res_hit`=0, `viol_valid`=1 and `viol_code` bit 0 (code 2'b01).
- R7: While a search runs, `xfer_ready` is low. A request offered then is held off until the search ends.
- R8: Four interrupt vector registers are written with `cfg_irq`=1. The register number is `cfg_idx[1:0]`, the address is `cfg_data[15:0]`, and `cfg_en` is the enable bit. An `irq_valid` vector that equals no enabled register sets `viol_valid` and `viol_code` bit 1 (code 2'b10) on the next edge. A matching vector raises nothing.
- R9: A table write with `cfg_irq`=0 stores `cfg_data` at entry `cfg_idx` and sets that entry's enable bit to `cfg_en`. An entry written with `cfg_en`=0 never matches.
- R10: A hit raises no forward-edge violation: `viol_code` bit 0 stays low during the result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_irq | input | 1 | 1 selects the interrupt vector registers, 0 selects the pair table |
| cfg_idx | input | IDX_W | Table entry number, or vector register number in the low bits |
| cfg_en | input | 1 | Enable bit stored with the write |
| cfg_data | input | 32 | Packed pair, or vector address in bits [15:0] |
| xfer_valid | input | 1 | A retired transfer is offered |
| xfer_ready | output | 1 | The block accepts a transfer on this edge |
| xfer_src | input | 16 | Address of the transfer instruction |
| xfer_tgt | input | 16 | Destination address |
| xfer_jump | input | 1 | 1 for an unconditional direct jump, 0 for a conditional branch |
| xfer_taken | input | 1 | Branch outcome |
| irq_valid | input | 1 | An interrupt entry is about to happen |
| irq_vec | input | 16 | Vector address of that entry |
| stall | output | 1 | Holds the core while a search runs |
| res_valid | output | 1 | One-cycle pulse that ends a search |
| res_hit | output | 1 | The searched pair was found |
| viol_valid | output | 1 | Some violation is reported this cycle |
| viol_code | output | 2 | Bit 0 forward edge, bit 1 interrupt entry |

## Verification
Transfers are presented as hits at the first entry, at a middle entry and at the highest enabled entry, so the bench can tell whether the search cost grows with the entry's position. Misses are tried against a sparse table, against a disabled entry that holds the exact pair, and against an empty table, which separates the end-of-search rule from the matching rule. Fall-through branches carrying a listed pair, and jumps whose taken flag is low, show whether the search trigger follows the transfer kind. Interrupt vectors that hit an enabled register, a disabled register and no register show how the enable bit gates the check.

// File: rtl/fxg_pkg.sv
package fxg_pkg;
  localparam int ADDR_W = 16;
  localparam int WORD_W = 2 * ADDR_W;

  typedef enum logic [1:0] {
    VC_NONE = 2'b00,
    VC_FWD  = 2'b01,
    VC_IRQ  = 2'b10
  } viol_code_e;

  function automatic logic [WORD_W-1:0] fxg_pack(input logic [ADDR_W-1:0] src,
                                                 input logic [ADDR_W-1:0] tgt);
    return {src, tgt};
  endfunction

  function automatic logic fxg_pair_eq(input logic [WORD_W-1:0] word,
                                       input logic [ADDR_W-1:0] src,
                                       input logic [ADDR_W-1:0] tgt);
    return (word[WORD_W-1:ADDR_W] == src) && (word[ADDR_W-1:0] == tgt);
  endfunction

  function automatic logic fxg_needs_lookup(input logic is_jump, input logic taken);
    return is_jump | taken;
  endfunction
endpackage

// File: rtl/fxg_pair_table.sv
module fxg_pair_table
  import fxg_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_vld,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_vld,
  output logic [IDX_W-1:0]  last_idx,
  output logic              any_vld
);
  logic [WORD_W-1:0] words [DEPTH];
  logic [DEPTH-1:0]  vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= wr_vld;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          words[g] <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(g))) begin
          words[g] <= wr_word;
        end
      end
    end
  endgenerate

  assign rd_word = words[rd_idx];
  assign rd_vld  = vld[rd_idx];
  assign any_vld = |vld;

  always_comb begin
    last_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i]) last_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fxg_scan_ctrl.sv
module fxg_scan_ctrl
  import fxg_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_look,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_tgt,
  output logic              req_ready,
  output logic              busy,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              rd_vld,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              any_vld,
  output logic              hit_now,
  output logic              end_now,
  output logic              res_valid,
  output logic              res_hit
);
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] tgt_q;

  assign rd_idx    = idx_q;
  assign req_ready = !busy;
  assign hit_now   = busy && rd_vld && fxg_pair_eq(rd_word, src_q, tgt_q);
  assign end_now   = busy && (!any_vld || (idx_q == last_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx_q     <= '0;
      src_q     <= '0;
      tgt_q     <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      if (!busy) begin
        if (req_valid && req_look) begin
          busy  <= 1'b1;
          idx_q <= '0;
          src_q <= req_src;
          tgt_q <= req_tgt;
        end
      end else if (hit_now) begin
        busy      <= 1'b0;
        res_valid <= 1'b1;
        res_hit   <= 1'b1;
      end else if (end_now) begin
        busy      <= 1'b0;
        res_valid <= 1'b1;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/fxg_irq_gate.sv
module fxg_irq_gate
  import fxg_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  localparam int SLOT_W = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              irq_valid,
  input  logic [ADDR_W-1:0] irq_vec,
  output logic              irq_match,
  output logic              irq_miss
);
  logic [ADDR_W-1:0]  vec_q [NUM_IRQ];
  logic [NUM_IRQ-1:0] en_q;
  logic [NUM_IRQ-1:0] slot_hit;

  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vec_q[g] <= '0;
          en_q[g]  <= 1'b0;
        end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
          vec_q[g] <= wr_addr;
          en_q[g]  <= wr_vld;
        end
      end
      assign slot_hit[g] = en_q[g] && (vec_q[g] == irq_vec);
    end
  endgenerate

  assign irq_match = |slot_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_miss <= 1'b0;
    else        irq_miss <= irq_valid && !irq_match;
  end
endmodule

// File: rtl/fwd_xfer_guard.sv
module fwd_xfer_guard
  import fxg_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NUM_IRQ = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int SLOT_W = $clog2(NUM_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_irq,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_en,
  input  logic [31:0]      cfg_data,
  input  logic             xfer_valid,
  output logic             xfer_ready,
  input  logic [15:0]      xfer_src,
  input  logic [15:0]      xfer_tgt,
  input  logic             xfer_jump,
  input  logic             xfer_taken,
  input  logic             irq_valid,
  input  logic [15:0]      irq_vec,
  output logic             stall,
  output logic             res_valid,
  output logic             res_hit,
  output logic             viol_valid,
  output logic [1:0]       viol_code
);
  logic [WORD_W-1:0] rd_word_w;
  logic              rd_vld_w;
  logic [IDX_W-1:0]  rd_idx_w;
  logic [IDX_W-1:0]  last_idx_w;
  logic              any_vld_w;
  logic              look_w;
  logic              hit_now_w;
  logic              end_now_w;
  logic              irq_match_w;
  logic              irq_miss_w;
  logic              fwd_miss_w;

  assign look_w = fxg_needs_lookup(xfer_jump, xfer_taken);

  fxg_pair_table #(.DEPTH(DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we && !cfg_irq),
    .wr_idx   (cfg_idx),
    .wr_vld   (cfg_en),
    .wr_word  (cfg_data),
    .rd_idx   (rd_idx_w),
    .rd_word  (rd_word_w),
    .rd_vld   (rd_vld_w),
    .last_idx (last_idx_w),
    .any_vld  (any_vld_w)
  );

  fxg_scan_ctrl #(.DEPTH(DEPTH)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (xfer_valid),
    .req_look  (look_w),
    .req_src   (xfer_src),
    .req_tgt   (xfer_tgt),
    .req_ready (xfer_ready),
    .busy      (stall),
    .rd_idx    (rd_idx_w),
    .rd_word   (rd_word_w),
    .rd_vld    (rd_vld_w),
    .last_idx  (last_idx_w),
    .any_vld   (any_vld_w),
    .hit_now   (hit_now_w),
    .end_now   (end_now_w),
    .res_valid (res_valid),
    .res_hit   (res_hit)
  );

  fxg_irq_gate #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we && cfg_irq),
    .wr_slot   (cfg_idx[SLOT_W-1:0]),
    .wr_vld    (cfg_en),
    .wr_addr   (cfg_data[ADDR_W-1:0]),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec),
    .irq_match (irq_match_w),
    .irq_miss  (irq_miss_w)
  );

  assign fwd_miss_w = res_valid && !res_hit;
  assign viol_code  = (fwd_miss_w ? VC_FWD : VC_NONE) | (irq_miss_w ? VC_IRQ : VC_NONE);
  assign viol_valid = |viol_code;
endmodule

// File: rtl/fxg_checker.sv
module fxg_checker #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_valid,
  input logic       xfer_ready,
  input logic       xfer_look,
  input logic       stall,
  input logic       res_valid,
  input logic       res_hit,
  input logic       viol_valid,
  input logic [1:0] viol_code,
  input logic       irq_valid,
  input logic       irq_match
);
  localparam int CNT_W = $clog2(DEPTH + 2) + 1;
  logic [CNT_W-1:0] stall_run;

  always_ff @(posedge clk) begin
    if (!rst_n)     stall_run <= '0;
    else if (stall) stall_run <= stall_run + CNT_W'(1);
    else            stall_run <= '0;
  end

  assert_lookup_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && xfer_look) |=> stall);

  assert_skip_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && !xfer_look) |=> (!stall && !res_valid));

  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !xfer_ready);

  assert_result_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !stall);

  assert_scan_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_run <= CNT_W'(DEPTH));

  assert_miss_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (viol_valid && viol_code[0]));

  assert_hit_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> !viol_code[0]);

  assert_irq_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_match) |=> (viol_valid && viol_code[1]));

  assert_irq_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_match) |=> !viol_code[1]);
endmodule

bind fwd_xfer_guard fxg_checker #(.DEPTH(DEPTH)) u_fxg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_look  (look_w),
  .stall      (stall),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .viol_valid (viol_valid),
  .viol_code  (viol_code),
  .irq_valid  (irq_valid),
  .irq_match  (irq_match_w)
);

// File: tb/test_fwd_xfer_guard.sv
module test_fwd_xfer_guard;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);

  typedef struct packed {
    logic        hit;
    logic [31:0] due;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_irq = 1'b0, cfg_en = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic xfer_valid = 1'b0, xfer_jump = 1'b0, xfer_taken = 1'b0;
  logic [15:0] xfer_src = '0, xfer_tgt = '0;
  logic irq_valid = 1'b0;
  logic [15:0] irq_vec = '0;
  logic xfer_ready, stall, res_valid, res_hit, viol_valid;
  logic [1:0] viol_code;

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;
  exp_t sb_q[$];
  logic [31:0] m_word [DEPTH];
  logic        m_vld  [DEPTH];
  logic        irq_phase = 1'b0;

  fwd_xfer_guard #(.DEPTH(DEPTH)) i_fwd_xfer_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_irq(cfg_irq), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_data(cfg_data), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_src(xfer_src), .xfer_tgt(xfer_tgt), .xfer_jump(xfer_jump), .xfer_taken(xfer_taken),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .stall(stall), .res_valid(res_valid),
    .res_hit(res_hit), .viol_valid(viol_valid), .viol_code(viol_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model of the search rules (R2, R5, R6, R9), kept apart from the RTL.
  function automatic exp_t predict(input logic [15:0] src, input logic [15:0] tgt);
    exp_t e;
    int last;
    last = -1;
    e.hit = 1'b0;
    e.due = 32'd0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_vld[i]) begin
        last = i;
        if (!e.hit && m_word[i][31:16] == src && m_word[i][15:0] == tgt) begin
          e.hit = 1'b1;
          e.due = 32'(i + 1);
        end
      end
    end
    if (!e.hit) e.due = (last < 0) ? 32'd1 : 32'(last + 1);
    return e;
  endfunction

  task automatic write_cfg(input logic irq_sel, input int idx, input logic en, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_irq = irq_sel; cfg_idx = IDX_W'(idx); cfg_en = en; cfg_data = data;
    if (!irq_sel) begin
      m_word[idx] = data;
      m_vld[idx]  = en;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [15:0] src, input logic [15:0] tgt, input logic jmp, input logic tkn);
    exp_t e;
    logic look;
    look = jmp | tkn;
    @(negedge clk);
    xfer_valid = 1'b1; xfer_src = src; xfer_tgt = tgt; xfer_jump = jmp; xfer_taken = tkn;
    while (!xfer_ready) @(negedge clk);
    e = predict(src, tgt);
    e.due = e.due + cyc + 1;
    if (look) sb_q.push_back(e);
    @(negedge clk);
    xfer_valid = 1'b0;
    if (look) check(stall && !xfer_ready, "R7 stall and ready during search", {stall, xfer_ready}, 2'b10);
    else      check(!stall && xfer_ready, "R3 fall-through starts no search", {stall, xfer_ready}, 2'b01);
  endtask

  task automatic wait_drain();
    while (sb_q.size() != 0 || stall) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic irq_try(input logic [15:0] vec, input logic expect_bad, input string req);
    @(negedge clk);
    irq_valid = 1'b1; irq_vec = vec;
    @(negedge clk);
    irq_valid = 1'b0;
    check(viol_code[1] == expect_bad && viol_valid == expect_bad, req,
          {viol_valid, viol_code}, {expect_bad, expect_bad, 1'b0});
  endtask

  // Monitor: pops expected results as the design reports them.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R3 result with no pending search", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(res_hit == e.hit, "R2 hit flag", res_hit, e.hit);
        check(cyc == e.due, e.hit ? "R5 hit latency" : "R6 miss latency", cyc, e.due);
        check(viol_code[0] == !e.hit, e.hit ? "R10 no violation on hit" : "R6 forward code 01",
              viol_code, {1'b0, !e.hit});
      end
    end else if (rst_n && !irq_phase && viol_valid) begin
      check(1'b0, "R10 stray violation", viol_code, 0);
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_word[i] = '0; m_vld[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check(!stall && xfer_ready && !res_valid && !viol_valid && viol_code == 2'b00,
          "R1 reset state", {stall, xfer_ready, res_valid, viol_valid, viol_code}, 6'b010000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!stall && xfer_ready, "R1 idle after reset", {stall, xfer_ready}, 2'b01);

    write_cfg(1'b0, 0, 1'b1, {16'h0100, 16'h0140});
    write_cfg(1'b0, 1, 1'b1, {16'h0104, 16'h0200});
    write_cfg(1'b0, 2, 1'b1, {16'h0120, 16'h0110});
    write_cfg(1'b0, 3, 1'b0, {16'h0300, 16'h0340});   // disabled, R9
    write_cfg(1'b0, 4, 1'b1, {16'h0400, 16'h0480});
    write_cfg(1'b0, 7, 1'b1, {16'h0700, 16'h0010});

    send(16'h0100, 16'h0140, 1'b0, 1'b1);  // R4 taken branch, hit at entry 0 (R5)
    wait_drain();
    send(16'h0400, 16'h0480, 1'b1, 1'b0);  // R4 jump with taken low, hit at entry 4
    wait_drain();
    send(16'h0700, 16'h0010, 1'b1, 1'b1);  // R5 hit at highest entry
    wait_drain();
    send(16'h0100, 16'h0144, 1'b1, 1'b0);  // R6 target mismatch, R2
    wait_drain();
    send(16'h0104, 16'h0140, 1'b0, 1'b1);  // R2 source mismatch
    wait_drain();
    send(16'h0300, 16'h0340, 1'b1, 1'b0);  // R9 disabled entry misses
    wait_drain();
    send(16'h0120, 16'h0110, 1'b0, 1'b0);  // R3 fall-through branch
    repeat (12) @(negedge clk);
    check(sb_q.size() == 0 && !stall, "R3 no search after fall-through", sb_q.size(), 0);
    send(16'h0104, 16'h0200, 1'b1, 1'b0);  // R7 back-to-back, second held off
    send(16'h0120, 16'h0110, 1'b0, 1'b1);
    wait_drain();

    for (int i = 0; i < DEPTH; i++) write_cfg(1'b0, i, 1'b0, 32'h0);
    send(16'h0100, 16'h0140, 1'b1, 1'b0);  // R6 empty table, one cycle
    wait_drain();

    irq_phase = 1'b1;
    write_cfg(1'b1, 0, 1'b1, 32'h0000_0800);
    write_cfg(1'b1, 1, 1'b0, 32'h0000_0900);
    write_cfg(1'b1, 2, 1'b1, 32'h0000_0A00);
    irq_try(16'h0800, 1'b0, "R8 enabled vector accepted");
    irq_try(16'h0900, 1'b1, "R8 disabled vector rejected");
    irq_try(16'h0C00, 1'b1, "R8 unknown vector rejected");
    irq_try(16'h0A00, 1'b0, "R8 second enabled vector accepted");
    @(negedge clk);
    check(!viol_valid, "R8 violation is a single pulse", viol_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule